// File: doc/BRIEF.md
# LZSS Scan-Stimulus Decompressor

This block rebuilds a scan-chain stimulus stream from LZSS codewords. Codewords arrive one at a time over a valid/ready handshake. Each one is either a literal that carries a single symbol or a back-reference that names a run of earlier symbols. The block emits the rebuilt stream as one symbol per clock over its own valid/ready handshake, so it can feed a scan chain directly.

A history window holds the symbols emitted most recently. Every emitted symbol is shifted into it, whether it came from a literal or from a copied run. On acceptance, a codeword is split into its fields. One shared window address then reads the addressed symbol together with the symbols that follow it, and the whole run is latched. A three-state controller (initialise, decode, output) stays in output until the run is exhausted, then returns to decode for the next codeword.

The window size, the longest run and the symbol width are parameters. The defaults are a 256-entry window, a 5-symbol run limit and 8-bit symbols.

Top module: `lzss_scan_decomp`

## Requirements
- R1: While reset is asserted, and after it is released until the first codeword is accepted, `cw_ready` can only rise once the controller has passed through initialisation, and `sym_valid` stays low.
- R2: A codeword whose most significant bit is 0 is a literal. The block emits exactly one symbol, equal to `cw_data[SYM_W-1:0]`.
- R3: A codeword whose most significant bit is 1 is a match. Its position is `cw_data[LEN_W+POS_W-1:LEN_W]` and its length code is `cw_data[LEN_W-1:0]`. It emits min(code+2, LOOK) symbols, with POS_W = ceil(log2(WIN)) and LEN_W = ceil(log2(LOOK-1)).
- R4: Position p refers to the symbol emitted p+1 symbols before the match begins, so position 0 is the newest one. Successive symbols of a run follow in emission order.
- R5: A run that extends beyond the newest symbol repeats the symbols of the same run with period p+1 (overlapping copy).
- R6: The window is cleared to zero during initialisation. Any reference to a slot not yet written yields symbol 0.
- R7: `cw_ready` is high only in the decode state and never together with `sym_valid`. Acceptance of a codeword makes `sym_valid` high in the following cycle.
- R8: In output, one symbol is offered per cycle and advances on each `sym_valid && sym_ready`. After the last symbol of a run is taken, `cw_ready` is high in the next cycle.
- R9: While `sym_valid` is high and `sym_ready` is low, `sym_data` holds its value and the stream does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cw_valid | input | 1 | Codeword offered |
| cw_ready | output | 1 | Block can take a codeword (decode state) |
| cw_data | input | CW_W (11) | Codeword: flag in the top bit, then literal or position/length |
| sym_valid | output | 1 | Output symbol valid |
| sym_ready | input | 1 | Scan side accepts the symbol |
| sym_data | output | SYM_W (8) | Output symbol |

## Verification
A codeword accepted at a clock edge has its first symbol on `sym_data`, with `sym_valid` high, right after that same edge. Each symbol taken at an edge exposes the next one right after it. Once the last symbol of a run is taken, `cw_ready` rises right after that edge. After reset is released, `cw_ready` rises three edges later: two synchroniser stages and one initialisation cycle. The bench keeps a behavioural model of the window and of the controller state. At every falling edge it first advances the model by the handshakes it issued one edge earlier, then compares both handshake flags and the data. A stalled symbol is also compared with its value one cycle earlier.

// File: rtl/lzss_dec_pkg.sv
package lzss_dec_pkg;
  typedef enum logic [1:0] {
    ST_INIT   = 2'd0,
    ST_DECODE = 2'd1,
    ST_OUTPUT = 2'd2
  } dec_state_e;
endpackage

// File: rtl/lzss_fields.sv
// Splits a codeword into flag, literal, position and run length (minus one).
module lzss_fields #(
  parameter int SYM_W = 8,
  parameter int POS_W = 8,
  parameter int LEN_W = 2,
  parameter int LOOK  = 5,
  parameter int CW_W  = 11,
  parameter int CNT_W = 3
) (
  input  logic [CW_W-1:0]  cw,
  output logic             is_match,
  output logic [SYM_W-1:0] lit,
  output logic [POS_W-1:0] pos,
  output logic [CNT_W-1:0] last
);
  logic [LEN_W-1:0] code;

  assign is_match = cw[CW_W-1];
  assign lit      = cw[SYM_W-1:0];
  assign pos      = cw[LEN_W +: POS_W];
  assign code     = cw[LEN_W-1:0];

  // run length = code + 2, clamped to LOOK (R3); last = length - 1
  always_comb begin
    int run_m1;
    run_m1 = int'(code) + 1;
    if (run_m1 > LOOK - 1) run_m1 = LOOK - 1;
    last = is_match ? CNT_W'(run_m1) : '0;
  end
endmodule

// File: rtl/lzss_window.sv
// History window, newest symbol in slot 0, with a shared-select run read-out.
module lzss_window #(
  parameter int SYM_W = 8,
  parameter int WIN   = 256,
  parameter int LOOK  = 5,
  parameter int POS_W = 8,
  localparam int LK_W = (LOOK > 1) ? $clog2(LOOK) : 1
) (
  input  logic                        clk,
  input  logic                        rst_ni,
  input  logic                        clear,
  input  logic                        shift_en,
  input  logic [SYM_W-1:0]            shift_sym,
  input  logic [POS_W-1:0]            rd_pos,
  output logic [LOOK-1:0][SYM_W-1:0]  rd_run
);
  logic [SYM_W-1:0] hist [WIN];

  for (genvar i = 0; i < WIN; i++) begin : g_slot
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (clear)         hist[i] <= '0;
        else if (shift_en) hist[i] <= shift_sym;
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (clear)         hist[i] <= '0;
        else if (shift_en) hist[i] <= hist[i-1];
      end
    end
  end

  // One address selects the symbol at rd_pos plus the LOOK-1 that followed it.
  // Taps past the newest slot wrap onto earlier taps of the same run (R5).
  always_comb begin
    logic [LOOK-1:0][SYM_W-1:0] taps;
    taps = '0;
    for (int k = 0; k < LOOK; k++) begin
      if (rd_pos >= POS_W'(k)) begin
        taps[k] = hist[rd_pos - POS_W'(k)];
      end else begin
        taps[k] = taps[LK_W'(k - 1 - int'(rd_pos))];
      end
    end
    rd_run = taps;
  end

  p_shift_newest_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (shift_en && !clear) |=> (hist[0] == $past(shift_sym)));

  p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    clear |=> (hist[0] == '0 && hist[WIN-1] == '0));
endmodule

// File: rtl/lzss_ctrl.sv
// Three-state controller: initialise, decode (accept), output (emit run).
module lzss_ctrl
  import lzss_dec_pkg::*;
#(
  parameter int SYM_W = 8,
  parameter int LOOK  = 5,
  parameter int CNT_W = 3
) (
  input  logic                        clk,
  input  logic                        rst_ni,
  input  logic                        cw_valid,
  output logic                        cw_ready,
  input  logic                        is_match,
  input  logic [SYM_W-1:0]            lit,
  input  logic [CNT_W-1:0]            last_in,
  input  logic [LOOK-1:0][SYM_W-1:0]  rd_run,
  output logic                        sym_valid,
  input  logic                        sym_ready,
  output logic [SYM_W-1:0]            sym_data,
  output logic                        clear,
  output logic                        shift_en
);
  dec_state_e                  state_q, state_d;
  logic [CNT_W-1:0]            cnt_q, cnt_d;
  logic [CNT_W-1:0]            last_q, last_d;
  logic [LOOK-1:0][SYM_W-1:0]  run_q, run_d;
  logic                        load, fire, at_last;

  assign cw_ready  = (state_q == ST_DECODE);
  assign sym_valid = (state_q == ST_OUTPUT);
  assign load      = cw_ready & cw_valid;
  assign fire      = sym_valid & sym_ready;
  assign at_last   = (cnt_q == last_q);
  assign sym_data  = run_q[cnt_q];
  assign clear     = (state_q == ST_INIT);
  assign shift_en  = fire;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    last_d  = last_q;
    run_d   = run_q;
    unique case (state_q)
      ST_INIT: state_d = ST_DECODE;
      ST_DECODE: begin
        if (cw_valid) begin
          state_d = ST_OUTPUT;
          cnt_d   = '0;
          last_d  = last_in;
          if (is_match) begin
            run_d = rd_run;
          end else begin
            run_d    = '0;
            run_d[0] = lit;
          end
        end
      end
      ST_OUTPUT: begin
        if (sym_ready) begin
          if (at_last) state_d = ST_DECODE;
          else         cnt_d   = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_INIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_INIT;
      cnt_q   <= '0;
      last_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      last_q  <= last_d;
    end
  end

  // run register is datapath: loaded on acceptance only, no reset
  always_ff @(posedge clk) begin
    if (load) run_q <= run_d;
  end

  p_init_once_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_INIT) |=> (state_q == ST_DECODE));

  p_accept_to_output_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (cw_valid && cw_ready) |=> (sym_valid && !cw_ready));

  p_handshake_excl_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    !(cw_ready && sym_valid));

  p_last_to_decode_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (fire && at_last) |=> cw_ready);

  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    sym_valid |-> (cnt_q <= last_q && int'(last_q) < LOOK));

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (sym_valid && !sym_ready) |=> (sym_valid && $stable(sym_data)));
endmodule

// File: rtl/lzss_scan_decomp.sv
// LZSS decompressor feeding a scan chain one symbol per clock.
module lzss_scan_decomp #(
  parameter int SYM_W = 8,
  parameter int WIN   = 256,
  parameter int LOOK  = 5,
  localparam int POS_W = $clog2(WIN),
  localparam int LEN_W = $clog2(LOOK - 1),
  localparam int CNT_W = $clog2(LOOK),
  localparam int PAY_W = (SYM_W > POS_W + LEN_W) ? SYM_W : POS_W + LEN_W,
  localparam int CW_W  = PAY_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cw_valid,
  output logic             cw_ready,
  input  logic [CW_W-1:0]  cw_data,
  output logic             sym_valid,
  input  logic             sym_ready,
  output logic [SYM_W-1:0] sym_data
);
  logic                       rst_meta, rst_sync_n;
  logic                       is_match, clear, shift_en;
  logic [SYM_W-1:0]           lit;
  logic [POS_W-1:0]           pos;
  logic [CNT_W-1:0]           last;
  logic [LOOK-1:0][SYM_W-1:0] rd_run;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  lzss_fields #(
    .SYM_W(SYM_W), .POS_W(POS_W), .LEN_W(LEN_W),
    .LOOK(LOOK), .CW_W(CW_W), .CNT_W(CNT_W)
  ) u_fields (
    .cw(cw_data), .is_match(is_match), .lit(lit), .pos(pos), .last(last)
  );

  lzss_window #(
    .SYM_W(SYM_W), .WIN(WIN), .LOOK(LOOK), .POS_W(POS_W)
  ) u_window (
    .clk(clk), .rst_ni(rst_sync_n), .clear(clear), .shift_en(shift_en),
    .shift_sym(sym_data), .rd_pos(pos), .rd_run(rd_run)
  );

  lzss_ctrl #(
    .SYM_W(SYM_W), .LOOK(LOOK), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst_ni(rst_sync_n), .cw_valid(cw_valid), .cw_ready(cw_ready),
    .is_match(is_match), .lit(lit), .last_in(last), .rd_run(rd_run),
    .sym_valid(sym_valid), .sym_ready(sym_ready), .sym_data(sym_data),
    .clear(clear), .shift_en(shift_en)
  );
endmodule

// File: tb/lzss_scan_decomp_bench.sv
module lzss_scan_decomp_bench;
  localparam int SYM_W = 8;
  localparam int WIN   = 256;
  localparam int LOOK  = 5;
  localparam int POS_W = 8;
  localparam int LEN_W = 2;
  localparam int CW_W  = 11;
  localparam int LIMIT = 50000;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cw_valid;
  logic             cw_ready;
  logic [CW_W-1:0]  cw_data;
  logic             sym_valid;
  logic             sym_ready;
  logic [SYM_W-1:0] sym_data;

  always #2.5 clk = ~clk;  // 200 MHz

  lzss_scan_decomp u_lzss_scan_decomp (
    .clk(clk), .rst_n(rst_n), .cw_valid(cw_valid), .cw_ready(cw_ready),
    .cw_data(cw_data), .sym_valid(sym_valid), .sym_ready(sym_ready),
    .sym_data(sym_data)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [CW_W-1:0]  cwq[$];
  logic [SYM_W-1:0] hist[$];
  logic [SYM_W-1:0] exp_sym[$];
  string            exp_tag[$];
  int               emitted = 0;

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [CW_W-1:0] mk_lit(input int s);
    return {1'b0, 2'b00, SYM_W'(s)};
  endfunction

  function automatic logic [CW_W-1:0] mk_match(input int p, input int code);
    return {1'b1, POS_W'(p), LEN_W'(code)};
  endfunction

  // Behavioural model: expand one codeword into expected symbols.
  task automatic expand(input logic [CW_W-1:0] cw);
    logic [SYM_W-1:0] s;
    if (!cw[CW_W-1]) begin
      s = cw[SYM_W-1:0];
      exp_sym.push_back(s); exp_tag.push_back("R2");
      hist.push_front(s); void'(hist.pop_back());
    end else begin
      int p, n, base;
      p = int'(cw[LEN_W +: POS_W]);
      n = int'(cw[LEN_W-1:0]) + 2;
      if (n > LOOK) n = LOOK;
      base = emitted;
      for (int k = 0; k < n; k++) begin
        s = hist[p];
        exp_sym.push_back(s);
        if (k > p)             exp_tag.push_back("R5");
        else if (p - k >= base) exp_tag.push_back("R6");
        else                   exp_tag.push_back("R3 R4");
        hist.push_front(s); void'(hist.pop_back());
      end
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin : watchdog
    repeat (LIMIT * 2) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin : main
    bool_t_dummy();
  end

  task automatic bool_t_dummy();
    bit in_out, take, give, stalled;
    logic [CW_W-1:0]  pend;
    logic [SYM_W-1:0] prev_data;
    int seen, cyc;

    rst_n = 1'b0; cw_valid = 1'b0; sym_ready = 1'b0; cw_data = '0;
    for (int i = 0; i < WIN; i++) hist.push_back('0);

    // R1: quiet during reset
    repeat (4) begin
      @(negedge clk);
      check("R1 cw_ready in reset", int'(cw_ready), 0);
      check("R1 sym_valid in reset", int'(sym_valid), 0);
    end
    rst_n = 1'b1;
    seen = 0;
    for (int i = 0; i < 10 && seen == 0; i++) begin
      @(negedge clk);
      check("R1 sym_valid after reset", int'(sym_valid), 0);
      if (cw_ready) seen = i + 1;
    end
    // synchroniser (2) + initialisation (1): ready at third falling edge
    check("R1 ready latency", seen, 3);

    // directed codewords
    cwq.push_back(mk_match(255, 3));   // R6: unwritten, five zeros
    cwq.push_back(mk_match(0, 0));     // R6: two zeros
    cwq.push_back(mk_lit(8'hA1));
    cwq.push_back(mk_lit(8'hB2));
    cwq.push_back(mk_lit(8'hC3));
    cwq.push_back(mk_match(0, 3));     // R5: C3 x5
    cwq.push_back(mk_match(7, 2));     // R4: A1 B2 C3 C3
    cwq.push_back(mk_match(1, 3));     // R5: period two
    cwq.push_back(mk_match(3, 1));     // R3: length three
    cwq.push_back(mk_match(200, 0));   // R6
    cwq.push_back(mk_lit(8'h00));
    cwq.push_back(mk_lit(8'hFF));
    cwq.push_back(mk_match(2, 3));     // R5 with period three
    for (int i = 0; i < 350; i++) begin
      if ($urandom_range(0, 2) == 0) cwq.push_back(mk_lit($urandom_range(0, 255)));
      else cwq.push_back(mk_match($urandom_range(0, (i < 200) ? 12 : 255),
                                  $urandom_range(0, 3)));
    end

    in_out = 0; take = 0; give = 0; stalled = 0; prev_data = '0; pend = '0;
    cyc = 0;
    while ((cwq.size() > 0 || in_out) && cyc < LIMIT) begin
      // advance model by handshakes issued one edge earlier
      if (take) begin
        expand(pend);
        in_out = 1;
      end
      if (give) begin
        void'(exp_sym.pop_front()); void'(exp_tag.pop_front());
        emitted++;
        if (exp_sym.size() == 0) in_out = 0;
      end
      // compare
      check("R7 cw_ready", int'(cw_ready), int'(!in_out));
      check("R8 sym_valid", int'(sym_valid), int'(in_out));
      if (in_out && exp_sym.size() > 0)
        check({exp_tag[0], " sym_data"}, int'(sym_data), int'(exp_sym[0]));
      if (stalled)
        check("R9 stalled data", int'(sym_data), int'(prev_data));
      // drive next cycle
      sym_ready = (cyc < 300) ? 1'b1 : ($urandom_range(0, 3) != 0);
      cw_valid  = (cwq.size() > 0) && ((cyc < 300) || ($urandom_range(0, 4) != 0));
      cw_data   = (cwq.size() > 0) ? cwq[0] : '0;
      take = !in_out && cw_valid;
      if (take) pend = cwq.pop_front();
      give    = in_out && sym_ready;
      stalled = in_out && !sym_ready;
      prev_data = sym_data;
      cyc++;
      @(negedge clk);
      cw_valid = 1'b0;
    end
    if (cyc >= LIMIT) begin
      n_bad++;
      $display("FAIL R8 stream: actual incomplete expected complete");
    end
    finished = 1;
    summary();
    $finish;
  endtask
endmodule